// File: doc/BRIEF.md
# Physical Address Range Decoder

This block sits between a processor's load/store and fetch path and the targets on its physical bus. Each cycle it may take one request: a 32-bit physical address, a transfer size, an access kind (read, write or instruction fetch), write data and an endian mode. It finds which target owns the address and raises that target's select. It passes on the address minus the base of the matched window, and it orders the data bytes for the chosen endian mode. Accesses that hit no window, or that the target does not allow, raise an error flag and select nothing. An unmapped read still returns an all-ones value sized to the request.

The map is fixed by parameters. Two windows belong to the boot ROM: its main window and an alias that returns the same data. There is one window for on-board RAM, and two I/O windows: the memory-controller register space and a read-only identification word. Read data comes from the selected target on `mem_bytes` as a raw byte vector, the byte at the lowest address in bits 7:0. The block turns it into the value the processor expects. Write data leaves on `rsp_wbytes` in the same raw byte order.

For each access kind the block keeps a one-entry memory of the last ROM or RAM window it matched. A request that falls inside that remembered window skips the ordered search, and `rsp_hit` reports this.

Top module: `addr_range_decoder`

## Requirements
- R1: Windows are searched in this order: ROM 0xFFC00000–0xFFFFFFFF, ROM alias 0x40000000–0x403FFFFF, RAM 0x00000000–0x007FFFFF, controller I/O 0x50F40000–0x50F4FFFF, identification 0x5FFFFFFC–0x5FFFFFFF. Both bounds are inclusive and the first match wins. `rsp_class` reports 0 for unmapped, 1 for ROM (either window), 2 for RAM and 3 for either I/O window.
- R2: `rsp_offset` equals the request address minus the base of the matched window (the alias base for alias hits). It is 0 when nothing matched.
- R3: A request accepted at a clock edge produces `rsp_valid` and all other response outputs one cycle later. At most one of the four selects is high. ROM and alias hits share `rsp_sel_rom`.
- R4: An unmapped access raises `rsp_err` and no select. For an unmapped read, `rsp_rvalue` is 0xFF, 0xFFFF or 0xFFFFFFFF for 1, 2 or 4 bytes. An unmapped write is dropped and `rsp_wbytes` stays 0.
- R5: A write to a ROM window, or a fetch from an I/O window, raises `rsp_err`, selects nothing and leaves `rsp_wbytes` at 0. `rsp_class` still names the window.
- R6: Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. On a non-error response, `rsp_rvalue` holds the first n bytes of `mem_bytes`. With `req_le`=0 the lowest-address byte is the most significant byte of the n-byte value. With `req_le`=1 it is the least significant. Unused upper bits are 0. On any other error, `rsp_rvalue` is 0.
- R7: On an allowed write, byte k of `rsp_wbytes` (bits 8k+7:8k) is the byte written at offset+k. In big-endian mode the top byte of the n-byte write data goes to offset+0. In little-endian mode the bottom byte does. Lanes at k ≥ n are 0. On any non-write response `rsp_wbytes` is 0.
- R8: Reads (kind 0, and kind 3, which acts as a read), writes (kind 1) and fetches (kind 2) each keep their own remembered window. A miss that matches a window loads it into that kind's memory: RAM for writes, ROM or RAM for reads and fetches. I/O windows are never loaded. `rsp_hit` is 1 exactly when the address lies inside that kind's remembered window.
- R9: After reset, no remembered window is valid, so the first access of each kind reports `rsp_hit`=0. All response outputs are 0 while in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Physical address |
| req_size | input | 2 | Size code: 0=1 byte, 1=2 bytes, 2/3=4 bytes |
| req_kind | input | 2 | 0=read, 1=write, 2=fetch, 3=read |
| req_wdata | input | 32 | Write value, right-aligned |
| req_le | input | 1 | 1 selects little-endian ordering |
| mem_bytes | input | 32 | Raw bytes from the selected target, byte k in bits 8k+7:8k |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_class | output | 2 | 0 unmapped, 1 ROM, 2 RAM, 3 I/O |
| rsp_sel_rom | output | 1 | ROM select |
| rsp_sel_ram | output | 1 | RAM select |
| rsp_sel_ctl | output | 1 | Controller I/O select |
| rsp_sel_id | output | 1 | Identification register select |
| rsp_offset | output | 32 | Offset within the matched window |
| rsp_err | output | 1 | Unmapped or disallowed access |
| rsp_hit | output | 1 | Served from the remembered window |
| rsp_wbytes | output | 32 | Write bytes in address order |
| rsp_rvalue | output | 32 | Formatted read value |

## Verification
A stale or wrong remembered window shows up as a flipped `rsp_hit` on the very next access of that kind. If it carried a wrong base, it would also show as a wrong `rsp_offset` in that same response. A misplaced window bound or a broken search order shows on the response to any address near a boundary, one cycle after the request. The reference model therefore drives many addresses at the first and last byte of each window and just beyond them. It interleaves the three access kinds so that one kind's memory being overwritten by another's would be exposed at once.

// File: rtl/addr_range_decoder.sv
module addr_range_decoder #(
  parameter logic [31:0] ROM_BASE = 32'hFFC0_0000,
  parameter logic [31:0] ROM_LAST = 32'hFFFF_FFFF,
  parameter logic [31:0] MIR_BASE = 32'h4000_0000,
  parameter logic [31:0] MIR_LAST = 32'h403F_FFFF,
  parameter logic [31:0] RAM_BASE = 32'h0000_0000,
  parameter logic [31:0] RAM_LAST = 32'h007F_FFFF,
  parameter logic [31:0] CTL_BASE = 32'h50F4_0000,
  parameter logic [31:0] CTL_LAST = 32'h50F4_FFFF,
  parameter logic [31:0] ID_BASE  = 32'h5FFF_FFFC,
  parameter logic [31:0] ID_LAST  = 32'h5FFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic [1:0]  req_kind,
  input  logic [31:0] req_wdata,
  input  logic        req_le,
  input  logic [31:0] mem_bytes,
  output logic        rsp_valid,
  output logic [1:0]  rsp_class,
  output logic        rsp_sel_rom,
  output logic        rsp_sel_ram,
  output logic        rsp_sel_ctl,
  output logic        rsp_sel_id,
  output logic [31:0] rsp_offset,
  output logic        rsp_err,
  output logic        rsp_hit,
  output logic [31:0] rsp_wbytes,
  output logic [31:0] rsp_rvalue
);
  localparam logic [2:0] T_NONE = 3'd0, T_ROM = 3'd1, T_RAM = 3'd2, T_CTL = 3'd3, T_ID = 3'd4;
  localparam logic [1:0] K_WR = 2'd1, K_FE = 2'd2;
  localparam int NKIND = 3;

  function automatic logic inside_win(input logic [31:0] a, input logic [31:0] b, input logic [31:0] l);
    return (a - b) <= (l - b);
  endfunction

  logic        hv [NKIND];
  logic [31:0] hs [NKIND];
  logic [31:0] he [NKIND];
  logic        hrom [NKIND];

  logic [1:0]  kidx;
  logic        hit, allowed, load;
  logic [2:0]  tgt;
  logic [31:0] wstart, wlast, wfmt;
  logic [1:0]  r_size, r_kind;
  logic        r_le;

  assign kidx = (req_kind == 2'd3) ? 2'd0 : req_kind;
  assign hit  = hv[kidx] && inside_win(req_addr, hs[kidx], he[kidx]);

  always_comb begin
    tgt = T_NONE; wstart = '0; wlast = '0;
    if      (inside_win(req_addr, ROM_BASE, ROM_LAST)) begin tgt = T_ROM; wstart = ROM_BASE; wlast = ROM_LAST; end
    else if (inside_win(req_addr, MIR_BASE, MIR_LAST)) begin tgt = T_ROM; wstart = MIR_BASE; wlast = MIR_LAST; end
    else if (inside_win(req_addr, RAM_BASE, RAM_LAST)) begin tgt = T_RAM; wstart = RAM_BASE; wlast = RAM_LAST; end
    else if (inside_win(req_addr, CTL_BASE, CTL_LAST)) begin tgt = T_CTL; wstart = CTL_BASE; wlast = CTL_LAST; end
    else if (inside_win(req_addr, ID_BASE,  ID_LAST))  begin tgt = T_ID;  wstart = ID_BASE;  wlast = ID_LAST;  end
    if (hit) begin
      tgt    = hrom[kidx] ? T_ROM : T_RAM;
      wstart = hs[kidx];
      wlast  = he[kidx];
    end
  end

  assign allowed = (tgt != T_NONE) &&
                   !(req_kind == K_WR && tgt == T_ROM) &&
                   !(req_kind == K_FE && (tgt == T_CTL || tgt == T_ID));
  assign load = req_valid && !hit &&
                (tgt == T_RAM || (tgt == T_ROM && req_kind != K_WR));

  always_comb begin
    wfmt = '0;
    if (req_size == 2'd0)      wfmt = {24'd0, req_wdata[7:0]};
    else if (req_size == 2'd1) wfmt = req_le ? {16'd0, req_wdata[15:0]}
                                             : {16'd0, req_wdata[7:0], req_wdata[15:8]};
    else                       wfmt = req_le ? req_wdata
                                             : {req_wdata[7:0], req_wdata[15:8], req_wdata[23:16], req_wdata[31:24]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NKIND; k++) begin
        hv[k] <= 1'b0; hs[k] <= '0; he[k] <= '0; hrom[k] <= 1'b0;
      end
      rsp_valid <= 1'b0; rsp_class <= '0; rsp_offset <= '0; rsp_err <= 1'b0; rsp_hit <= 1'b0;
      rsp_sel_rom <= 1'b0; rsp_sel_ram <= 1'b0; rsp_sel_ctl <= 1'b0; rsp_sel_id <= 1'b0;
      rsp_wbytes <= '0; r_size <= '0; r_kind <= '0; r_le <= 1'b0;
    end else begin
      if (load) begin
        hv[kidx] <= 1'b1; hs[kidx] <= wstart; he[kidx] <= wlast; hrom[kidx] <= (tgt == T_ROM);
      end
      rsp_valid   <= req_valid;
      rsp_class   <= !req_valid ? 2'd0 : (tgt == T_ROM) ? 2'd1 : (tgt == T_RAM) ? 2'd2 :
                     (tgt == T_NONE) ? 2'd0 : 2'd3;
      rsp_offset  <= (req_valid && tgt != T_NONE) ? req_addr - wstart : '0;
      rsp_err     <= req_valid && !allowed;
      rsp_hit     <= req_valid && hit;
      rsp_sel_rom <= req_valid && allowed && tgt == T_ROM;
      rsp_sel_ram <= req_valid && allowed && tgt == T_RAM;
      rsp_sel_ctl <= req_valid && allowed && tgt == T_CTL;
      rsp_sel_id  <= req_valid && allowed && tgt == T_ID;
      rsp_wbytes  <= (req_valid && allowed && req_kind == K_WR) ? wfmt : '0;
      r_size      <= req_size;
      r_kind      <= req_kind;
      r_le        <= req_le;
    end
  end

  always_comb begin
    rsp_rvalue = '0;
    if (rsp_valid && !rsp_err) begin
      if (r_size == 2'd0)      rsp_rvalue = {24'd0, mem_bytes[7:0]};
      else if (r_size == 2'd1) rsp_rvalue = r_le ? {16'd0, mem_bytes[15:0]}
                                                 : {16'd0, mem_bytes[7:0], mem_bytes[15:8]};
      else                     rsp_rvalue = r_le ? mem_bytes
                                                 : {mem_bytes[7:0], mem_bytes[15:8], mem_bytes[23:16], mem_bytes[31:24]};
    end else if (rsp_valid && rsp_class == 2'd0 && (r_kind == 2'd0 || r_kind == 2'd3)) begin
      rsp_rvalue = (r_size == 2'd0) ? 32'h0000_00FF : (r_size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    end
  end

  assert_onehot_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_sel_rom, rsp_sel_ram, rsp_sel_ctl, rsp_sel_id}));
  assert_resp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_err && !rsp_hit);
  assert_unmapped_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_class == 2'd0) |-> rsp_err && rsp_wbytes == 32'd0);
  assert_err_nosel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !(rsp_sel_rom || rsp_sel_ram || rsp_sel_ctl || rsp_sel_id));
  assert_rom_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == K_WR && inside_win(req_addr, ROM_BASE, ROM_LAST)) |=> rsp_err && !rsp_sel_rom);
  assert_hit_memonly_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> !rsp_err && (rsp_class == 2'd1 || rsp_class == 2'd2));
endmodule

// File: tb/sim_addr_range_decoder.sv
module sim_addr_range_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_le = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0, mem_bytes = '0;
  logic [1:0] req_size = '0, req_kind = '0;
  logic rsp_valid, rsp_sel_rom, rsp_sel_ram, rsp_sel_ctl, rsp_sel_id, rsp_err, rsp_hit;
  logic [1:0] rsp_class;
  logic [31:0] rsp_offset, rsp_wbytes, rsp_rvalue;

  always #10 clk = ~clk;

  addr_range_decoder u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_kind(req_kind), .req_wdata(req_wdata), .req_le(req_le),
    .mem_bytes(mem_bytes), .rsp_valid(rsp_valid), .rsp_class(rsp_class), .rsp_sel_rom(rsp_sel_rom),
    .rsp_sel_ram(rsp_sel_ram), .rsp_sel_ctl(rsp_sel_ctl), .rsp_sel_id(rsp_sel_id),
    .rsp_offset(rsp_offset), .rsp_err(rsp_err), .rsp_hit(rsp_hit), .rsp_wbytes(rsp_wbytes),
    .rsp_rvalue(rsp_rvalue));

  int checks = 0, fails = 0;
  bit finished = 0;

  // model map: order is search order; tclass 1 ROM, 2 RAM, 3 I/O; tsel 0 rom 1 ram 2 ctl 3 id
  longint lo [5] = '{64'hFFC0_0000, 64'h4000_0000, 64'h0000_0000, 64'h50F4_0000, 64'h5FFF_FFFC};
  longint hi [5] = '{64'hFFFF_FFFF, 64'h403F_FFFF, 64'h007F_FFFF, 64'h50F4_FFFF, 64'h5FFF_FFFF};
  int tclass [5] = '{1, 1, 2, 3, 3};
  int tsel [5]   = '{0, 0, 1, 2, 3};

  bit mv [3] = '{0, 0, 0};
  longint ms [3], me [3];
  int mcls [3];

  bit e_valid = 0, e_err = 0, e_hit = 0;
  logic [1:0] e_class = '0;
  logic [3:0] e_sel = '0;
  logic [31:0] e_off = '0, e_wb = '0, e_rv = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R3 rsp_valid", {31'd0, rsp_valid}, {31'd0, e_valid});
    chk("R1 rsp_class", {30'd0, rsp_class}, {30'd0, e_class});
    chk("R3/R5 selects", {28'd0, rsp_sel_id, rsp_sel_ctl, rsp_sel_ram, rsp_sel_rom}, {28'd0, e_sel});
    chk("R2 rsp_offset", rsp_offset, e_off);
    chk("R4/R5 rsp_err", {31'd0, rsp_err}, {31'd0, e_err});
    chk("R8/R9 rsp_hit", {31'd0, rsp_hit}, {31'd0, e_hit});
    chk("R7 rsp_wbytes", rsp_wbytes, e_wb);
    chk("R6/R4 rsp_rvalue", rsp_rvalue, e_rv);
  endtask

  task automatic step(input bit v, input logic [31:0] a, input logic [1:0] sz, input logic [1:0] kd,
                      input logic [31:0] wd, input bit le, input logic [31:0] mb);
    int k, idx, n, cls;
    bit h, ok, isrd;
    longint base;
    logic [31:0] val;
    @(negedge clk);
    compare();
    req_valid = v; req_addr = a; req_size = sz; req_kind = kd; req_wdata = wd; req_le = le; mem_bytes = mb;
    k = (kd == 2'd3) ? 0 : int'(kd);
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    isrd = (kd == 2'd0 || kd == 2'd3);
    idx = -1;
    for (int i = 0; i < 5; i++) if (idx < 0 && longint'(a) >= lo[i] && longint'(a) <= hi[i]) idx = i;
    h = v && mv[k] && longint'(a) >= ms[k] && longint'(a) <= me[k];
    cls = (idx < 0) ? 0 : tclass[idx];
    base = (idx < 0) ? 0 : lo[idx];
    ok = (idx >= 0) && !(kd == 2'd1 && cls == 1) && !(kd == 2'd2 && cls == 3);
    e_valid = v;
    e_hit = h;
    e_class = v ? cls[1:0] : 2'd0;
    e_err = v && !ok;
    e_off = (v && idx >= 0) ? 32'(longint'(a) - base) : 32'd0;
    e_sel = (v && ok) ? 4'(1 << tsel[idx]) : 4'd0;
    e_wb = '0;
    if (v && ok && kd == 2'd1)
      for (int b = 0; b < n; b++)
        e_wb[8*b +: 8] = le ? wd[8*b +: 8] : wd[8*(n-1-b) +: 8];
    val = '0;
    if (v && ok) begin
      for (int b = 0; b < n; b++)
        if (le) val[8*b +: 8] = mb[8*b +: 8];
        else val = (val << 8) | {24'd0, mb[8*b +: 8]};
    end else if (v && idx < 0 && isrd) begin
      for (int b = 0; b < n; b++) val[8*b +: 8] = 8'hFF;
    end
    e_rv = val;
    if (v && !h && idx >= 0 && (cls == 2 || (cls == 1 && kd != 2'd1))) begin
      mv[k] = 1; ms[k] = lo[idx]; me[k] = hi[idx]; mcls[k] = cls;
    end
  endtask

  function automatic logic [31:0] pick_addr();
    int r, w;
    longint span;
    r = $urandom_range(0, 9);
    if (r >= 5) return $urandom();
    w = r;
    span = hi[w] - lo[w];
    case ($urandom_range(0, 4))
      0: return 32'(lo[w]);
      1: return 32'(hi[w]);
      2: return 32'(lo[w] - 1);
      3: return 32'(hi[w] + 1);
      default: return 32'(lo[w] + ({32'd0, $urandom()} % (span + 1)));
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    // R9: outputs idle during reset
    @(negedge clk); compare();
    rst_n = 1'b1;
    // R9: first access of each kind misses; R8 second hits
    step(1, 32'h0000_0100, 2'd2, 2'd0, 0, 0, 32'h4433_2211);
    step(1, 32'h007F_FFFF, 2'd0, 2'd0, 0, 0, 32'h0000_00AB);
    step(1, 32'h0000_0040, 2'd2, 2'd1, 32'hA1B2_C3D4, 0, 0);  // R7 BE 4B
    step(1, 32'h0000_0044, 2'd2, 2'd1, 32'hA1B2_C3D4, 1, 0);  // R7 LE 4B, R8 hit
    step(1, 32'h0000_0046, 2'd1, 2'd1, 32'h0000_5A6B, 0, 0);  // R7 BE 2B
    step(1, 32'h0000_0047, 2'd0, 2'd1, 32'h0000_0077, 1, 0);  // R7 1B
    step(1, 32'hFFC0_0000, 2'd2, 2'd2, 0, 0, 32'h7C08_02A6);  // fetch miss
    step(1, 32'hFFFF_FFFC, 2'd2, 2'd2, 0, 0, 32'h1122_3344);  // fetch hit
    step(1, 32'h4000_0010, 2'd1, 2'd0, 0, 0, 32'h0000_BEEF);  // R1 alias, R6 BE 2B
    step(1, 32'h4000_0012, 2'd1, 2'd0, 0, 1, 32'h0000_BEEF);  // R6 LE 2B, hit
    step(1, 32'hFFC0_0004, 2'd3, 2'd3, 0, 1, 32'hCAFE_F00D);  // main ROM misses alias entry
    step(1, 32'hFFC0_0000, 2'd2, 2'd1, 32'h1234_5678, 0, 0);  // R5 ROM write
    step(1, 32'h5FFF_FFFC, 2'd2, 2'd2, 0, 0, 32'h0);          // R5 fetch from I/O
    step(1, 32'h50F4_0008, 2'd0, 2'd0, 0, 0, 32'h01);         // R8 I/O never cached
    step(1, 32'h50F4_0008, 2'd0, 2'd0, 0, 0, 32'h01);
    step(1, 32'h5FFF_FFFE, 2'd0, 2'd0, 0, 0, 32'h5A);
    step(1, 32'h0080_0000, 2'd0, 2'd0, 0, 0, 0);              // R4 unmapped reads
    step(1, 32'h403F_FFFF + 1, 2'd1, 2'd0, 0, 1, 0);
    step(1, 32'hFFBF_FFFF, 2'd2, 2'd3, 0, 0, 0);
    step(1, 32'h5FFF_FFFB, 2'd2, 2'd1, 32'hFFFF_0000, 0, 0);  // R4 unmapped write dropped
    step(1, 32'h50F3_FFFF, 2'd2, 2'd2, 0, 0, 32'h9);          // unmapped fetch
    step(0, 32'h0000_0000, 2'd0, 2'd0, 0, 0, 0);
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 7) != 0, pick_addr(), 2'($urandom()), 2'($urandom()),
           $urandom(), 1'($urandom()), $urandom());
    step(0, 0, 0, 0, 0, 0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule